// File: doc/BRIEF.md
# Conditional branch unit

This block owns the program counter of a small processor core whose arithmetic sets four status flags: negative (N), zero (Z), signed overflow (V) and carry/borrow (C). Each cycle it is given a 4-bit condition selector, the current flags, the address of a two-byte relative branch instruction and that instruction's 8-bit signed displacement. It reports at once whether the branch would be taken. On a cycle with the step enable high it loads either the branch target or the fall-through address into the program counter.

The condition set covers single-flag tests, an unconditional and a null condition, the four signed relations and the unsigned relations. The signed relations are built from N^V, and the unsigned ones from C and C|Z. All of them assume the flags come from a preceding subtract, compare or test. Equality does not depend on signedness. The two unsigned relations that match a single carry test are reached through the carry codes. The target is relative to the byte that follows the branch, so a displacement of 0xFE branches to the instruction itself.

Only plain control and status pins are used. There is no streaming data path, so the pins carry no valid/ready handshake. The caller holds `step` low for any cycle in which the program counter must not move.

Top module: `cond_branch_unit`

## Requirements
- R1: Selector 0 is always taken and selector 1 is never taken, whatever the flags.
- R2: Selector 2 is taken when C=0 (unsigned higher-or-same) and selector 3 when C=1 (unsigned lower). Flags bit 0 is C.
- R3: Selector 4 is taken when Z=1 and selector 5 when Z=0. Flags bit 2 is Z.
- R4: Selector 6 is taken when N=1 and selector 7 when N=0. Flags bit 3 is N.
- R5: Selector 8 is taken when V=0 and selector 9 when V=1. Flags bit 1 is V.
- R6: Selector 10 (signed greater-or-equal) is taken when N^V=0, and selector 11 (signed less-than) when N^V=1.
- R7: Selector 12 (signed greater-than) is taken when Z|(N^V)=0, and selector 13 (signed less-or-equal) when Z|(N^V)=1.
- R8: Selector 14 (unsigned higher) is taken when C|Z=0, and selector 15 (lower-or-same) when C|Z=1.
- R9: On a taken step, the next program counter is instr_addr + 2 + the sign-extended displacement, modulo 2^AW. For example, 0x4006 with 0xFC gives 0x4004, and 0x4004 with 0x02 gives 0x4008.
- R10: On a step that is not taken, the next program counter is instr_addr + 2, modulo 2^AW.
- R11: `taken` follows its inputs in the same cycle. `pc` changes only on a clock edge with `step` high.
- R12: While `rst_n` is low, `pc` equals `reset_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_vec | input | AW | Value loaded into pc during reset |
| step | input | 1 | Enables the pc update at this edge |
| cond_sel | input | 4 | Branch condition selector |
| flags | input | 4 | {N, Z, V, C} |
| instr_addr | input | AW | Address of the branch instruction |
| disp | input | DW | Signed displacement |
| taken | output | 1 | Branch decision, combinational |
| pc | output | AW | Program counter register |

## Verification
`taken` depends on no register, so the bench drives each stimulus on a falling edge and compares `taken` with its model two nanoseconds later, within the same cycle. `pc` is due one rising edge after the stimulus. The model updates its expected counter at that edge, and the bench compares `pc` one nanosecond after the edge, before the next stimulus is applied. Steps with the enable low are compared the same way, and the expected value on those steps is the unchanged counter.

// File: rtl/cond_branch_pkg.sv
package cond_branch_pkg;
  typedef enum logic [3:0] {
    SEL_ALWAYS = 4'd0,
    SEL_NEVER  = 4'd1,
    SEL_C_CLR  = 4'd2,
    SEL_C_SET  = 4'd3,
    SEL_Z_SET  = 4'd4,
    SEL_Z_CLR  = 4'd5,
    SEL_N_SET  = 4'd6,
    SEL_N_CLR  = 4'd7,
    SEL_V_CLR  = 4'd8,
    SEL_V_SET  = 4'd9,
    SEL_S_GE   = 4'd10,
    SEL_S_LT   = 4'd11,
    SEL_S_GT   = 4'd12,
    SEL_S_LE   = 4'd13,
    SEL_U_HI   = 4'd14,
    SEL_U_LS   = 4'd15
  } branch_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } status_flags_t;
endpackage

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
  import cond_branch_pkg::*;
(
  input  logic [3:0]    sel_i,
  input  status_flags_t fl_i,
  output logic          go_o
);
  branch_sel_e sel;
  logic sgn_less;
  logic uns_le;

  assign sel      = branch_sel_e'(sel_i);
  assign sgn_less = fl_i.n ^ fl_i.v;
  assign uns_le   = fl_i.c | fl_i.z;

  always_comb begin
    unique case (sel)
      SEL_ALWAYS: go_o = 1'b1;
      SEL_NEVER:  go_o = 1'b0;
      SEL_C_CLR:  go_o = ~fl_i.c;
      SEL_C_SET:  go_o = fl_i.c;
      SEL_Z_SET:  go_o = fl_i.z;
      SEL_Z_CLR:  go_o = ~fl_i.z;
      SEL_N_SET:  go_o = fl_i.n;
      SEL_N_CLR:  go_o = ~fl_i.n;
      SEL_V_CLR:  go_o = ~fl_i.v;
      SEL_V_SET:  go_o = fl_i.v;
      SEL_S_GE:   go_o = ~sgn_less;
      SEL_S_LT:   go_o = sgn_less;
      SEL_S_GT:   go_o = ~(fl_i.z | sgn_less);
      SEL_S_LE:   go_o = fl_i.z | sgn_less;
      SEL_U_HI:   go_o = ~uns_le;
      SEL_U_LS:   go_o = uns_le;
      default:    go_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_branch_target.sv
module cond_branch_target #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int ILEN = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] disp_i,
  output logic [AW-1:0] seq_o,
  output logic [AW-1:0] tgt_o
);
  localparam logic [AW-1:0] INC = AW'(ILEN);
  logic [AW-1:0] disp_ext;

  generate
    if (AW > DW) begin : g_ext
      assign disp_ext = {{(AW-DW){disp_i[DW-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[AW-1:0];
    end
  endgenerate

  assign seq_o = addr_i + INC;
  assign tgt_o = seq_o + disp_ext;
endmodule

// File: rtl/cond_branch_pcreg.sv
module cond_branch_pcreg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rvec_i,
  input  logic          en_i,
  input  logic          sel_tgt_i,
  input  logic [AW-1:0] seq_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_o <= rvec_i;
    else if (en_i)  pc_o <= sel_tgt_i ? tgt_i : seq_i;
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cond_branch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reset_vec,
  input  logic          step,
  input  logic [3:0]    cond_sel,
  input  logic [3:0]    flags,
  input  logic [AW-1:0] instr_addr,
  input  logic [DW-1:0] disp,
  output logic          taken,
  output logic [AW-1:0] pc
);
  localparam int ILEN = 2;
  status_flags_t fl;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] tgt_addr;

  assign fl = status_flags_t'(flags);

  cond_branch_eval u_eval (
    .sel_i (cond_sel),
    .fl_i  (fl),
    .go_o  (taken)
  );

  cond_branch_target #(.AW(AW), .DW(DW), .ILEN(ILEN)) u_tgt (
    .addr_i (instr_addr),
    .disp_i (disp),
    .seq_o  (seq_addr),
    .tgt_o  (tgt_addr)
  );

  cond_branch_pcreg #(.AW(AW)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .rvec_i    (reset_vec),
    .en_i      (step),
    .sel_tgt_i (taken),
    .seq_i     (seq_addr),
    .tgt_i     (tgt_addr),
    .pc_o      (pc)
  );
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [3:0]    cond_sel,
  input logic [3:0]    flags,
  input logic [AW-1:0] instr_addr,
  input logic [DW-1:0] disp,
  input logic          taken,
  input logic [AW-1:0] pc
);
  localparam logic [AW-1:0] TWO = AW'(2);
  logic [AW-1:0] dx;
  assign dx = AW'($signed(disp));

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd0) |-> taken);  // R1
  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd1) |-> !taken);  // R1
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));  // R11
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !taken) |=> (pc == $past(instr_addr) + TWO));  // R10
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step && taken) |=> (pc == $past(instr_addr) + TWO + $past(dx)));  // R9
  AST_SIGNED_GT_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd12 && flags[2]) |-> !taken);  // R7
  AST_UNS_HI_NOT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd14 && flags[0]) |-> !taken);  // R8
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .step(step), .cond_sel(cond_sel), .flags(flags),
  .instr_addr(instr_addr), .disp(disp), .taken(taken), .pc(pc)
);

// File: tb/cond_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cond_branch_unit_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reset_vec = 16'h4000;
  logic          step = 1'b0;
  logic [3:0]    cond_sel = 4'd0;
  logic [3:0]    flags = 4'd0;
  logic [AW-1:0] instr_addr = '0;
  logic [DW-1:0] disp = '0;
  logic          taken;
  logic [AW-1:0] pc;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_pc;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #5 clk = ~clk;

  cond_branch_unit #(.AW(AW), .DW(DW)) dut_i (.*);

  function automatic bit ref_taken(int sel, int f);
    bit n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (sel)
      0: return 1;       1: return 0;        // R1
      2: return !c;      3: return c;        // R2
      4: return z;       5: return !z;       // R3
      6: return n;       7: return !n;       // R4
      8: return !v;      9: return v;        // R5
      10: return n == v; 11: return n != v;  // R6
      12: return !z && (n == v);             // R7
      13: return z || (n != v);
      14: return !c && !z;                   // R8
      default: return c || z;
    endcase
  endfunction

  function automatic string req_of(int sel);
    case (sel)
      0, 1: return "R1";   2, 3: return "R2";   4, 5: return "R3";
      6, 7: return "R4";   8, 9: return "R5";   10, 11: return "R6";
      12, 13: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic cmp(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic one(int sel, int f, int addr, int d, bit en);
    bit tk;
    int sd;
    @(negedge clk);
    cond_sel = sel[3:0]; flags = f[3:0];
    instr_addr = addr[AW-1:0]; disp = d[DW-1:0]; step = en;
    #2;
    tk = ref_taken(sel, f);
    cmp(req_of(sel), int'(taken), int'(tk));
    sd = (d & 255) >= 128 ? (d & 255) - 256 : (d & 255);
    if (en) exp_pc = tk ? ((addr + 2 + sd) & 16'hFFFF) : ((addr + 2) & 16'hFFFF);
    @(posedge clk);
    #1;
    cmp(en ? (tk ? "R9" : "R10") : "R11", int'(pc), exp_pc);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_pc = 16'h4000;
    repeat (3) @(posedge clk);
    #1;
    cmp("R12", int'(pc), exp_pc);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 examples
    one(0, 0, 16'h4006, 8'hFC, 1);
    one(0, 0, 16'h4004, 8'h02, 1);
    // wrap-around at the top and bottom of the address space
    one(0, 0, 16'hFFFE, 8'h7F, 1);
    one(0, 0, 16'h0001, 8'h80, 1);
    one(1, 15, 16'hFFFF, 8'h10, 1);  // R10 wrap
    // R11 step low holds pc
    one(0, 0, 16'h1234, 8'h20, 0);
    one(15, 5, 16'h2222, 8'h01, 0);
    // every selector against every flag combination
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 16; f++)
        one(s, f, 16'h3000 + s * 64 + f, (s * 17 + f * 29) & 255, 1);
    // pseudo-random mix
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      one(int'(lfsr[3:0]), int'(lfsr[7:4]), int'(lfsr[23:8]), int'(lfsr[31:24]),
          lfsr[2] | lfsr[9]);
    end
    // R12 reset again mid-run to another vector
    @(negedge clk);
    reset_vec = 16'h8000;
    rst_n = 1'b0;
    #2;
    exp_pc = 16'h8000;
    cmp("R12", int'(pc), exp_pc);
    @(negedge clk);
    rst_n = 1'b1;
    one(0, 0, 16'h8000, 8'hFE, 1);  // R9 branch to itself
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule